// File: doc/BRIEF.md
# Write-Through Snooping Coherence Controller

This block keeps a small direct-mapped, write-through cache coherent on a shared snooping bus. Each line has a tag and a single presence bit that reads as either present (valid) or absent (invalid). A processor load to a present line is answered from the local copy and never touches the bus. A load to an absent line fetches the word over the bus and installs it. Every store goes to the bus. A store that misses does not install the line, and a store that hits also updates the local copy.

The controller watches writes that other caches place on the bus. A foreign write to an address that this cache holds drops the local copy, so the next local load fetches fresh data. The processor side uses a valid/ready handshake with a one-cycle response pulse. The bus side raises a request, waits for a grant from an external arbiter, and then drives one command in the granted cycle. Because the arbiter grants one master at a time, all writes are ordered by grant.

Top module: `wt_snoop_ctrl`

## Requirements
- R1: Reset marks every line absent, so the first load to any address after reset reports a miss. No response is pending out of reset.
- R2: A load that hits a present line produces its response (cpuRespHit=1, the cached data) in the cycle after acceptance, with no bus request and no bus command.
- R3: A load that misses issues exactly one bus read (busCmdWrite=0) at the request address, returns busRdData with cpuRespHit=0, and installs the line so that a repeat load hits.
- R4: Every store issues exactly one bus write (busCmdWrite=1) carrying the request address and data, whether it hits or misses. The response follows in the cycle after the granted command, with cpuRespHit showing whether the line was present at acceptance.
- R5: A store that misses leaves the line absent, so a following load to that address misses.
- R6: A store that hits updates the local copy, so a following load hits and returns the stored data.
- R7: A snooped foreign write (snoopValid with snoopAddr) to an address held present makes that line absent.
- R8: A snooped foreign write to an address not held leaves every line untouched. This includes an address whose index matches a present line but whose tag differs.
- R9: A snoop and a processor load to the same address in the same cycle give the snoop priority. The load is reported as a miss and goes to the bus.
- R10: A snoop to the address being filled, in the same cycle as the fill data, leaves the line absent. The load still returns the fill data.
- R11: cpuReqReady is low while a bus grant or read data is awaited. busReq stays high until the grant arrives. A bus command appears only while busGrant is high.

Address layout: the low INDEX_W bits of an address select the line, and the remaining upper bits form the tag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpuReqValid | input | 1 | Processor request present |
| cpuReqReady | output | 1 | Controller can accept a request |
| cpuReqWrite | input | 1 | 1 = store, 0 = load |
| cpuReqAddr | input | ADDR_W | Request word address |
| cpuReqWdata | input | DATA_W | Store data |
| cpuRespValid | output | 1 | One-cycle response pulse |
| cpuRespRdata | output | DATA_W | Load data (zero for stores) |
| cpuRespHit | output | 1 | Line was present at acceptance |
| busReq | output | 1 | Request for bus ownership |
| busGrant | input | 1 | Arbiter grant |
| busCmdValid | output | 1 | Command driven this cycle |
| busCmdWrite | output | 1 | 1 = bus write, 0 = bus read |
| busCmdAddr | output | ADDR_W | Command address |
| busCmdWdata | output | DATA_W | Bus write data |
| busRdValid | input | 1 | Read data returned from memory |
| busRdData | input | DATA_W | Returned read data |
| snoopValid | input | 1 | Foreign bus write observed |
| snoopAddr | input | ADDR_W | Address of the foreign write |

## Verification
The assertions check the handshake and bus discipline on every cycle. They cover ready being low while the bus is in use, a request held until granted, commands only under grant, every accepted store reaching the bus, a load resolving either as an immediate hit or as a bus request, and the response that follows each write command and each fill. What the lines contain can only be shown by the bench's scenarios: the returned data values, whether a line was installed, kept or dropped after stores and foreign writes, and which side wins when a snoop collides with a lookup or a fill.

// File: rtl/wt_snoop_pkg.sv
package wt_snoop_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_WAITGNT = 2'd1,
    ST_WAITRD  = 2'd2
  } ctlState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic latchReq;    // capture the accepted request and its lookup result
    logic fillLine;    // install returned read data
    logic writeLocal;  // write-through store: refresh a present copy
    logic respHitNow;  // answer a load hit from the array
    logic respBus;     // answer a load miss from bus data
    logic respStore;   // answer a completed store
  } dpStrobe_t;

endpackage

// File: rtl/wt_snoop_dpath.sv
module wt_snoop_dpath
  import wt_snoop_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 8,
  parameter int INDEX_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpuReqWrite,
  input  logic [ADDR_W-1:0] cpuReqAddr,
  input  logic [DATA_W-1:0] cpuReqWdata,
  input  logic              snoopValid,
  input  logic [ADDR_W-1:0] snoopAddr,
  input  logic [DATA_W-1:0] busRdData,
  input  dpStrobe_t         strobe,
  output logic              lookHit,
  output logic              reqWriteQ,
  output logic [ADDR_W-1:0] reqAddrQ,
  output logic [DATA_W-1:0] reqWdataQ,
  output logic              cpuRespValid,
  output logic [DATA_W-1:0] cpuRespRdata,
  output logic              cpuRespHit
);

  localparam int LINES = 1 << INDEX_W;
  localparam int TAG_W = ADDR_W - INDEX_W;

  logic              validQ [LINES];
  logic [TAG_W-1:0]  tagQ   [LINES];
  logic [DATA_W-1:0] dataQ  [LINES];

  logic reqHitQ;

  logic [INDEX_W-1:0] inIdx, reqIdx, snIdx;
  logic [TAG_W-1:0]   inTag, reqTag, snTag;

  assign inIdx  = cpuReqAddr[INDEX_W-1:0];
  assign inTag  = cpuReqAddr[ADDR_W-1:INDEX_W];
  assign reqIdx = reqAddrQ[INDEX_W-1:0];
  assign reqTag = reqAddrQ[ADDR_W-1:INDEX_W];
  assign snIdx  = snoopAddr[INDEX_W-1:0];
  assign snTag  = snoopAddr[ADDR_W-1:INDEX_W];

  logic [LINES-1:0] snoopKill;
  logic [LINES-1:0] fillSel;
  logic [LINES-1:0] storeSel;
  logic             fillKill;

  // per-line snoop compare, fill select and store-hit select
  for (genvar g = 0; g < LINES; g++) begin : gLine
    assign snoopKill[g] = snoopValid && (snIdx == INDEX_W'(g)) &&
                          validQ[g] && (tagQ[g] == snTag);
    assign fillSel[g]   = strobe.fillLine && (reqIdx == INDEX_W'(g));
    assign storeSel[g]  = strobe.writeLocal && (reqIdx == INDEX_W'(g)) &&
                          validQ[g] && (tagQ[g] == reqTag) && !snoopKill[g];
  end

  // a foreign write to the very address being filled wins over the fill
  assign fillKill = snoopValid && (snoopAddr == reqAddrQ);

  // lookup of the incoming request; a same-cycle snoop to it masks the hit
  assign lookHit = validQ[inIdx] && (tagQ[inIdx] == inTag) &&
                   !(snoopValid && (snoopAddr == cpuReqAddr));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) validQ[i] <= 1'b0;
    end else begin
      for (int i = 0; i < LINES; i++) begin
        if (fillSel[i])        validQ[i] <= !fillKill;
        else if (snoopKill[i]) validQ[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < LINES; i++) begin
      if (fillSel[i]) begin
        tagQ[i]  <= reqTag;
        dataQ[i] <= busRdData;
      end else if (storeSel[i]) begin
        dataQ[i] <= reqWdataQ;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reqWriteQ <= 1'b0;
      reqAddrQ  <= '0;
      reqWdataQ <= '0;
      reqHitQ   <= 1'b0;
    end else if (strobe.latchReq) begin
      reqWriteQ <= cpuReqWrite;
      reqAddrQ  <= cpuReqAddr;
      reqWdataQ <= cpuReqWdata;
      reqHitQ   <= lookHit;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cpuRespValid <= 1'b0;
      cpuRespRdata <= '0;
      cpuRespHit   <= 1'b0;
    end else begin
      cpuRespValid <= strobe.respHitNow || strobe.respBus || strobe.respStore;
      if (strobe.respHitNow) begin
        cpuRespRdata <= dataQ[inIdx];
        cpuRespHit   <= 1'b1;
      end else if (strobe.respBus) begin
        cpuRespRdata <= busRdData;
        cpuRespHit   <= 1'b0;
      end else if (strobe.respStore) begin
        cpuRespRdata <= '0;
        cpuRespHit   <= reqHitQ;
      end
    end
  end

endmodule

// File: rtl/wt_snoop_fsm.sv
module wt_snoop_fsm
  import wt_snoop_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cpuReqValid,
  input  logic       cpuReqWrite,
  input  logic       lookHit,
  input  logic       reqWriteQ,
  input  logic       busGrant,
  input  logic       busRdValid,
  output logic       cpuReqReady,
  output logic       busReq,
  output logic       busCmdValid,
  output dpStrobe_t  strobe
);

  ctlState_e stateQ, stateD;

  always_ff @(posedge clk) begin
    if (!rst_n) stateQ <= ST_IDLE;
    else        stateQ <= stateD;
  end

  always_comb begin
    stateD      = stateQ;
    strobe      = '0;
    cpuReqReady = 1'b0;
    busReq      = 1'b0;
    busCmdValid = 1'b0;
    unique case (stateQ)
      ST_IDLE: begin
        cpuReqReady = 1'b1;
        if (cpuReqValid) begin
          strobe.latchReq = 1'b1;
          if (!cpuReqWrite && lookHit) strobe.respHitNow = 1'b1;
          else                         stateD = ST_WAITGNT;
        end
      end
      ST_WAITGNT: begin
        busReq = 1'b1;
        if (busGrant) begin
          busCmdValid = 1'b1;
          if (reqWriteQ) begin
            strobe.writeLocal = 1'b1;
            strobe.respStore  = 1'b1;
            stateD            = ST_IDLE;
          end else begin
            stateD = ST_WAITRD;
          end
        end
      end
      ST_WAITRD: begin
        if (busRdValid) begin
          strobe.fillLine = 1'b1;
          strobe.respBus  = 1'b1;
          stateD          = ST_IDLE;
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/wt_snoop_ctrl.sv
module wt_snoop_ctrl
  import wt_snoop_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 8,
  parameter int INDEX_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpuReqValid,
  output logic              cpuReqReady,
  input  logic              cpuReqWrite,
  input  logic [ADDR_W-1:0] cpuReqAddr,
  input  logic [DATA_W-1:0] cpuReqWdata,
  output logic              cpuRespValid,
  output logic [DATA_W-1:0] cpuRespRdata,
  output logic              cpuRespHit,
  output logic              busReq,
  input  logic              busGrant,
  output logic              busCmdValid,
  output logic              busCmdWrite,
  output logic [ADDR_W-1:0] busCmdAddr,
  output logic [DATA_W-1:0] busCmdWdata,
  input  logic              busRdValid,
  input  logic [DATA_W-1:0] busRdData,
  input  logic              snoopValid,
  input  logic [ADDR_W-1:0] snoopAddr
);

  dpStrobe_t         strobe;
  logic              lookHit;
  logic              reqWriteQ;
  logic [ADDR_W-1:0] reqAddrQ;
  logic [DATA_W-1:0] reqWdataQ;

  wt_snoop_fsm fsm_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cpuReqValid (cpuReqValid),
    .cpuReqWrite (cpuReqWrite),
    .lookHit     (lookHit),
    .reqWriteQ   (reqWriteQ),
    .busGrant    (busGrant),
    .busRdValid  (busRdValid),
    .cpuReqReady (cpuReqReady),
    .busReq      (busReq),
    .busCmdValid (busCmdValid),
    .strobe      (strobe)
  );

  wt_snoop_dpath #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .INDEX_W (INDEX_W)
  ) dpath_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .cpuReqWrite  (cpuReqWrite),
    .cpuReqAddr   (cpuReqAddr),
    .cpuReqWdata  (cpuReqWdata),
    .snoopValid   (snoopValid),
    .snoopAddr    (snoopAddr),
    .busRdData    (busRdData),
    .strobe       (strobe),
    .lookHit      (lookHit),
    .reqWriteQ    (reqWriteQ),
    .reqAddrQ     (reqAddrQ),
    .reqWdataQ    (reqWdataQ),
    .cpuRespValid (cpuRespValid),
    .cpuRespRdata (cpuRespRdata),
    .cpuRespHit   (cpuRespHit)
  );

  assign busCmdWrite = reqWriteQ;
  assign busCmdAddr  = reqAddrQ;
  assign busCmdWdata = reqWdataQ;

endmodule

// File: rtl/wt_snoop_ctrl_chk.sv
module wt_snoop_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic cpuReqValid,
  input logic cpuReqReady,
  input logic cpuReqWrite,
  input logic cpuRespValid,
  input logic cpuRespHit,
  input logic busReq,
  input logic busGrant,
  input logic busCmdValid,
  input logic busCmdWrite,
  input logic busRdValid
);

  // R11
  ready_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busReq |-> !cpuReqReady);

  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busReq && !busGrant) |=> busReq);

  // R11
  cmd_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busCmdValid |-> (busGrant && busReq));

  // R2
  load_split_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpuReqValid && cpuReqReady && !cpuReqWrite) |=> (cpuRespValid != busReq));

  // R2
  load_quick_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpuReqValid && cpuReqReady && !cpuReqWrite) |=> (!cpuRespValid || cpuRespHit));

  // R4
  store_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpuReqValid && cpuReqReady && cpuReqWrite) |=> busReq);

  // R4
  store_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busCmdValid && busCmdWrite) |=> cpuRespValid);

  // R3
  fill_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busRdValid && !busReq && !cpuReqReady) |=> (cpuRespValid && !cpuRespHit));

endmodule

bind wt_snoop_ctrl wt_snoop_ctrl_chk chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .cpuReqValid  (cpuReqValid),
  .cpuReqReady  (cpuReqReady),
  .cpuReqWrite  (cpuReqWrite),
  .cpuRespValid (cpuRespValid),
  .cpuRespHit   (cpuRespHit),
  .busReq       (busReq),
  .busGrant     (busGrant),
  .busCmdValid  (busCmdValid),
  .busCmdWrite  (busCmdWrite),
  .busRdValid   (busRdValid)
);

// File: tb/wt_snoop_ctrl_tb_top.sv
`timescale 1ns/1ps
module wt_snoop_ctrl_tb_top;

  localparam int ADDR_W  = 8;
  localparam int DATA_W  = 8;
  localparam int INDEX_W = 2;
  localparam int LINES   = 1 << INDEX_W;
  localparam int SPAN    = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpuReqValid = 1'b0, cpuReqWrite = 1'b0;
  logic [ADDR_W-1:0] cpuReqAddr = '0;
  logic [DATA_W-1:0] cpuReqWdata = '0;
  logic cpuReqReady, cpuRespValid, cpuRespHit;
  logic [DATA_W-1:0] cpuRespRdata;
  logic busReq, busCmdValid, busCmdWrite;
  logic [ADDR_W-1:0] busCmdAddr;
  logic [DATA_W-1:0] busCmdWdata;
  logic busGrant = 1'b0, busRdValid = 1'b0;
  logic [DATA_W-1:0] busRdData = '0;
  logic snoopValid = 1'b0;
  logic [ADDR_W-1:0] snoopAddr = '0;

  always #2 clk = ~clk;

  wt_snoop_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .INDEX_W(INDEX_W)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .cpuReqValid(cpuReqValid), .cpuReqReady(cpuReqReady), .cpuReqWrite(cpuReqWrite),
    .cpuReqAddr(cpuReqAddr), .cpuReqWdata(cpuReqWdata),
    .cpuRespValid(cpuRespValid), .cpuRespRdata(cpuRespRdata), .cpuRespHit(cpuRespHit),
    .busReq(busReq), .busGrant(busGrant), .busCmdValid(busCmdValid),
    .busCmdWrite(busCmdWrite), .busCmdAddr(busCmdAddr), .busCmdWdata(busCmdWdata),
    .busRdValid(busRdValid), .busRdData(busRdData),
    .snoopValid(snoopValid), .snoopAddr(snoopAddr)
  );

  int total = 0;
  int bad = 0;

  // memory image and reference line state
  logic [DATA_W-1:0] mem [1 << ADDR_W];
  bit refValid [LINES];
  int refTag   [LINES];

  // bus monitor / arbiter / memory state
  int gntDelay = 0, rdDelay = 0;
  int gCnt = 0, rdCnt = 0;
  bit rdPend = 0;
  int rdAddr = 0;
  int cmdCount = 0;
  bit lastCmdWrite = 0;
  int lastCmdAddr = 0, lastCmdData = 0;

  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && busCmdValid) begin
        cmdCount++;
        lastCmdWrite = busCmdWrite;
        lastCmdAddr  = busCmdAddr;
        lastCmdData  = busCmdWdata;
        if (busCmdWrite) mem[busCmdAddr] = busCmdWdata;
        else begin rdPend = 1; rdCnt = rdDelay; rdAddr = busCmdAddr; end
      end
      @(posedge clk); #1;
      if (busGrant) begin busGrant = 0; gCnt = 0; end
      else if (rst_n && busReq) begin
        if (gCnt >= gntDelay) busGrant = 1; else gCnt++;
      end
      if (busRdValid) busRdValid = 0;
      if (rdPend) begin
        if (rdCnt == 0) begin
          busRdValid = 1; busRdData = mem[rdAddr]; rdPend = 0;
        end else rdCnt--;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic snoopOnly(input int addr, input int data);
    int idx = addr % LINES;
    snoopValid = 1; snoopAddr = addr;
    mem[addr] = data;
    if (refValid[idx] && refTag[idx] == addr / LINES) refValid[idx] = 0;
    step();
    snoopValid = 0;
  endtask

  // one processor access with bench-side expectations
  task automatic access(input bit wr, input int addr, input int wd,
                        input bit snoopNow, input bit snoopFill, input int sdata,
                        input string req);
    int idx = addr % LINES;
    int tg  = addr / LINES;
    bit expHit;
    int expData;
    int cmd0 = cmdCount;
    int cyc = 0;
    bit fillHit = 0;
    if (snoopNow) begin
      mem[addr] = sdata;
      if (refValid[idx] && refTag[idx] == tg) refValid[idx] = 0;
    end
    expHit  = refValid[idx] && (refTag[idx] == tg);
    expData = mem[addr];
    check(cpuReqReady == 1, "R11", "ready when idle", cpuReqReady, 1);
    cpuReqValid = 1; cpuReqWrite = wr; cpuReqAddr = addr; cpuReqWdata = wd;
    snoopValid = snoopNow; snoopAddr = addr;
    forever begin
      step();
      cyc++;
      cpuReqValid = 0;
      snoopValid = 0;
      if (cpuRespValid) break;
      check(cpuReqReady == 0, "R11", "ready low while waiting", cpuReqReady, 0);
      if (snoopFill && busRdValid && !fillHit) begin
        fillHit = 1;
        snoopValid = 1; snoopAddr = addr;
        mem[addr] = sdata;
      end
      if (cyc > 60) begin
        check(0, req, "response timeout", cyc, 0);
        break;
      end
    end
    snoopValid = 0;
    check(cpuRespHit == expHit, req, "hit flag", cpuRespHit, expHit);
    if (wr) begin
      check(cmdCount == cmd0 + 1, req, "one bus write", cmdCount - cmd0, 1);
      check(lastCmdWrite == 1, req, "command is write", lastCmdWrite, 1);
      check(lastCmdAddr == addr, req, "write address", lastCmdAddr, addr);
      check(lastCmdData == (wd & 8'hFF), req, "write data", lastCmdData, wd & 8'hFF);
    end else if (expHit) begin
      check(cmdCount == cmd0, req, "hit makes no bus command", cmdCount - cmd0, 0);
      check(cyc == 1, req, "hit latency", cyc, 1);
      check(cpuRespRdata == expData, req, "hit data", cpuRespRdata, expData);
    end else begin
      check(cmdCount == cmd0 + 1, req, "one bus read", cmdCount - cmd0, 1);
      check(lastCmdWrite == 0, req, "command is read", lastCmdWrite, 0);
      check(lastCmdAddr == addr, req, "read address", lastCmdAddr, addr);
      check(cpuRespRdata == expData, req, "fill data", cpuRespRdata, expData);
      if (snoopFill) refValid[idx] = 0;
      else begin refValid[idx] = 1; refTag[idx] = tg; end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(0, "ALL", "watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int a = 0; a < (1 << ADDR_W); a++) mem[a] = (a * 7 + 3) & 8'hFF;
    for (int i = 0; i < LINES; i++) begin refValid[i] = 0; refTag[i] = 0; end
    repeat (3) step();
    rst_n = 1;
    step();
    // reset state
    check(cpuReqReady == 1, "R11", "ready after reset", cpuReqReady, 1);
    check(busReq == 0, "R11", "no bus request after reset", busReq, 0);
    check(cpuRespValid == 0, "R1", "no response after reset", cpuRespValid, 0);

    // R1: every line starts absent
    for (int a = 0; a < LINES; a++) access(0, a + LINES * 5, 0, 0, 0, 0, "R1");

    // R3 / R2: load sweep, miss then hit, varying grant and read latency
    for (int a = 0; a < SPAN; a++) begin
      gntDelay = a % 3; rdDelay = a % 4;
      access(0, a, 0, 0, 0, 0, (refValid[a % LINES] && refTag[a % LINES] == a / LINES) ? "R2" : "R3");
      access(0, a, 0, 0, 0, 0, "R2");
    end

    // R4 / R5 / R6: store sweep, even addresses made present first
    for (int a = 0; a < SPAN; a++) begin
      bit wasHeld;
      gntDelay = (a + 1) % 4; rdDelay = a % 2;
      if (a % 2 == 0) access(0, a, 0, 0, 0, 0, "R3");
      wasHeld = refValid[a % LINES] && refTag[a % LINES] == a / LINES;
      access(1, a, a ^ 8'h5A, 0, 0, 0, "R4");
      access(0, a, 0, 0, 0, 0, wasHeld ? "R6" : "R5");
    end

    // R8 / R7: foreign writes
    gntDelay = 1; rdDelay = 1;
    for (int i = 0; i < LINES; i++) begin
      access(0, i, 0, 0, 0, 0, "R3");
      snoopOnly(i + LINES, 8'hC0 + i);          // same index, other tag
      snoopOnly(200 + i, 8'hD0 + i);            // unrelated address
      access(0, i, 0, 0, 0, 0, "R8");
      snoopOnly(i, 8'hE0 + i);                  // held address
      access(0, i, 0, 0, 0, 0, "R7");
    end

    // R9: snoop and load to the same address in one cycle
    for (int i = 0; i < LINES; i++) begin
      gntDelay = i; rdDelay = 0;
      access(0, 16 + i, 0, 0, 0, 0, "R3");
      access(0, 16 + i, 0, 1, 0, 8'hA0 + i, "R9");
      access(0, 16 + i, 0, 0, 0, 0, "R9");
    end

    // R10: snoop collides with the fill of the same address
    for (int i = 0; i < LINES; i++) begin
      gntDelay = 0; rdDelay = i;
      snoopOnly(32 + i, 8'h11 * (i + 1));
      access(0, 32 + i, 0, 0, 1, 8'h90 + i, "R10");
      access(0, 32 + i, 0, 0, 0, 0, "R10");
    end

    repeat (3) step();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule